// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two up-counting timer/counter channels. Each channel keeps its count as a low byte and a high byte. A shared configuration register and a shared control register steer both channels. All of these registers sit behind a byte-wide write/read port. Counting advances on a machine-cycle tick input, which pulses once every twelve oscillator clocks.

Each channel can count ticks (timer function) or count falling edges on its own external count pin (counter function). Its run bit enables counting, and a gate pin can also qualify it. Four count layouts are available:
- a 13-bit count,
- a full 16-bit count,
- an 8-bit count that reloads itself from the high byte,
- a split layout. Here channel 0 becomes two independent byte counters and channel 1 stops.

The overflow flags go out to an interrupt controller, which clears them through per-flag acknowledge inputs. A one-cycle overflow pulse from channel 1 can drive a baud-rate generator.

Top module: `dual_timer_counter`

## Requirements
- R1: After reset, every register reads 00H, both flags are 0, and the overflow pulse is 0.
- R2: Register addresses are: 0 channel 0 low byte, 1 channel 0 high byte, 2 channel 1 low byte, 3 channel 1 high byte, 4 configuration, 5 control. Reads of these addresses return the stored value. Any other address reads 00H. Configuration bits [3:0] belong to channel 0 and bits [7:4] to channel 1. Within each nibble, bits [1:0] select the mode (0 = 13-bit, 1 = 16-bit, 2 = reload, 3 = split), bit 2 selects counter function and bit 3 is the gate enable. Control bit 0 is run 0, bit 1 is run 1, bit 2 is flag 0 and bit 3 is flag 1. Control bits [7:4] read as 0.
- R3: In timer function, with its run bit set and its gate enable at 0, a channel advances by exactly one per tick. With its run bit clear, the channel holds its count.
- R4: With the gate enable set, a running channel counts only on ticks where its gate pin (after synchronization) is high.
- R5: In counter function, the count pin is synchronized and then sampled on every tick. The count advances on a tick whose sample is 0 when the previous tick's sample was 1. A pulse that starts and ends between two ticks is not counted.
- R6: In 13-bit mode the count is formed by the high byte and low-byte bits [4:0]. Low-byte bits [7:5] keep their value. Rolling over from 1FFFH to 0 sets the channel's flag.
- R7: In 16-bit mode the count rolls over from FFFFH to 0000H and sets the flag. For channel 1, every overflow also raises the overflow pulse for exactly one cycle, visible together with the flag.
- R8: In reload mode only the low byte counts. On the tick after the low byte reaches FFH, it takes the high-byte value, the high byte is unchanged, and the flag is set.
- R9: Channel 1 in split mode holds its count even while run 1 is set.
- R10: Channel 0 in split mode runs as two byte counters. The low byte uses run 0 and sets flag 0 on wrap. The high byte counts every tick while run 1 is set and sets flag 1 on wrap, without raising the overflow pulse.
- R11: An asserted acknowledge input clears the corresponding flag on the next clock. A hardware overflow in the same cycle wins over the acknowledge.
- R12: A register write in the same cycle as an increment takes priority over the increment. Writing the control register sets or clears the flags directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_tick | input | 1 | Machine-cycle tick, one clock wide |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | BYTE_W | Write data |
| reg_rdata | output | BYTE_W | Read data for reg_addr (combinational) |
| cnt_pin | input | 2 | External count pins, one per channel |
| gate_pin | input | 2 | External gate pins, one per channel |
| flag_ack | input | 2 | Acknowledge inputs that clear flag 0 and flag 1 |
| ovf_flag | output | 2 | Overflow flags |
| t1_ovf_pulse | output | 1 | One-cycle pulse on each channel 1 overflow |

## Verification
Register writes are visible on the read port in the cycle after the write edge. Counts, flags and the overflow pulse change on the edge of the tick cycle, so they are due one clock after the tick is driven. The pulse falls again one clock later. The count and gate pins pass a two-stage synchronizer, so they must settle at least two clocks before the tick that samples them. The bench changes every input on the falling clock edge and keeps each pin steady for eleven idle clocks before each tick. It reads results on the falling edge right after the tick edge, and for the pulse also on the falling edge one clock after that.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   typedef enum logic [1:0] {
      MODE_13     = 2'd0,
      MODE_16     = 2'd1,
      MODE_RELOAD = 2'd2,
      MODE_SPLIT  = 2'd3
   } tmr_mode_e;

   // per-channel configuration nibble: gate enable, counter select, mode
   typedef struct packed {
      logic      gate_en;
      logic      ctr_sel;
      tmr_mode_e mode;
   } chan_cfg_t;

   localparam int CFG_W   = $bits(chan_cfg_t);
   localparam int NUM_CH  = 2;
   localparam int REG_CFG = 4;
   localparam int REG_CTL = 5;
endpackage

// File: rtl/tmr_pin_sync.sv
`timescale 1ns/1ps
module tmr_pin_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_pin_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] st_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st_q[s] <= '0;
            else        st_q[s] <= pin_i;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st_q[s] <= '0;
            else        st_q[s] <= st_q[s-1];
      end
   end

   assign sync_o = st_q[STAGES-1];
endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int M13_LOW  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tmr_mode_e         mode,
   input  logic              inc_main,
   input  logic              inc_hi,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] lo,
   output logic [BYTE_W-1:0] hi,
   output logic              ovf_main,
   output logic              ovf_hi
);
   localparam int WIDE_W = 2 * BYTE_W;
   localparam logic [M13_LOW-1:0] ONE_L = 1;
   localparam logic [BYTE_W-1:0]  ONE_B = 1;
   localparam logic [WIDE_W-1:0]  ONE_W = 1;

   if (M13_LOW < 1 || M13_LOW >= BYTE_W) begin : g_bad_low
      $error("tmr_chan: M13_LOW must lie between 1 and BYTE_W-1");
   end

   logic [BYTE_W-1:0] lo_n, hi_n;

   always_comb begin
      lo_n     = lo;
      hi_n     = hi;
      ovf_main = 1'b0;
      ovf_hi   = 1'b0;
      if (inc_main) begin
         case (mode)
            MODE_13: begin
               if (&lo[M13_LOW-1:0]) begin
                  lo_n[M13_LOW-1:0] = '0;
                  hi_n              = hi + ONE_B;
                  ovf_main          = &hi;
               end else begin
                  lo_n[M13_LOW-1:0] = lo[M13_LOW-1:0] + ONE_L;
               end
            end
            MODE_16: begin
               {hi_n, lo_n} = {hi, lo} + ONE_W;
               ovf_main     = &{hi, lo};
            end
            MODE_RELOAD: begin
               if (&lo) begin
                  lo_n     = hi;
                  ovf_main = 1'b1;
               end else begin
                  lo_n = lo + ONE_B;
               end
            end
            default: begin
               lo_n     = lo + ONE_B;
               ovf_main = &lo;
            end
         endcase
      end
      if (inc_hi) begin
         hi_n   = hi + ONE_B;
         ovf_hi = &hi;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo <= '0;
         hi <= '0;
      end else begin
         lo <= wr_lo ? wdata : lo_n;
         hi <= wr_hi ? wdata : hi_n;
      end
   end

   // R8: reload copies the high byte into the low byte
   assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_RELOAD && inc_main && (&lo) && !wr_lo) |=> (lo == $past(hi)));

   // R6: the unused low-byte bits never move in 13-bit mode
   assert_upper_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_13 && !wr_lo)
         |=> (lo[BYTE_W-1:M13_LOW] == $past(lo[BYTE_W-1:M13_LOW])));

   // R12: a write wins over an increment
   assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (lo == $past(wdata)));

   // R3: with no increment and no write the count holds
   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_main && !inc_hi && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi)));
endmodule

// File: rtl/dual_timer_counter.sv
`timescale 1ns/1ps
module dual_timer_counter
   import tmr_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int M13_LOW     = 5,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_tick,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic [BYTE_W-1:0] reg_rdata,
   input  logic [1:0]        cnt_pin,
   input  logic [1:0]        gate_pin,
   input  logic [1:0]        flag_ack,
   output logic [1:0]        ovf_flag,
   output logic              t1_ovf_pulse
);
   localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(REG_CFG);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(REG_CTL);

   if (BYTE_W < NUM_CH * CFG_W) begin : g_bad_byte
      $error("dual_timer_counter: BYTE_W too narrow for the configuration register");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("dual_timer_counter: ADDR_W must be at least 3");
   end

   chan_cfg_t         cfg_q [NUM_CH];
   logic [NUM_CH-1:0] run_q, flag_q, smp_q;
   logic              pulse_q;
   logic [NUM_CH-1:0] cnt_s, gate_s, fall, en_base;
   logic [NUM_CH-1:0] inc_main, inc_hi, wr_lo, wr_hi, ovf_main, ovf_hi, set_flag;
   logic [BYTE_W-1:0] cnt_lo [NUM_CH];
   logic [BYTE_W-1:0] cnt_hi [NUM_CH];
   logic              wr_cfg, wr_ctl;

   assign wr_cfg = reg_wr && (reg_addr == A_CFG);
   assign wr_ctl = reg_wr && (reg_addr == A_CTL);

   tmr_pin_sync #(.STAGES(SYNC_STAGES), .WIDTH(2*NUM_CH)) i_sync (
      .clk(clk), .rst_n(rst_n),
      .pin_i({gate_pin, cnt_pin}),
      .sync_o({gate_s, cnt_s})
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)        smp_q[i] <= 1'b0;
         else if (cyc_tick) smp_q[i] <= cnt_s[i];

      assign fall[i]    = cyc_tick & smp_q[i] & ~cnt_s[i];
      assign en_base[i] = cyc_tick & run_q[i] & (~cfg_q[i].gate_en | gate_s[i])
                          & (cfg_q[i].ctr_sel ? fall[i] : 1'b1);
      assign wr_lo[i]   = reg_wr && (reg_addr == ADDR_W'(2*i));
      assign wr_hi[i]   = reg_wr && (reg_addr == ADDR_W'(2*i+1));

      if (i == 0) begin : g_ch0
         assign inc_main[i] = en_base[i];
         assign inc_hi[i]   = cyc_tick & run_q[1] & (cfg_q[0].mode == MODE_SPLIT);
      end else begin : g_chn
         assign inc_main[i] = en_base[i] & (cfg_q[i].mode != MODE_SPLIT);
         assign inc_hi[i]   = 1'b0;
      end

      tmr_chan #(.BYTE_W(BYTE_W), .M13_LOW(M13_LOW)) i_chan (
         .clk(clk), .rst_n(rst_n),
         .mode(cfg_q[i].mode),
         .inc_main(inc_main[i]), .inc_hi(inc_hi[i]),
         .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(reg_wdata),
         .lo(cnt_lo[i]), .hi(cnt_hi[i]),
         .ovf_main(ovf_main[i]), .ovf_hi(ovf_hi[i])
      );
   end

   // channel 0 split high byte borrows flag 1
   assign set_flag[0] = ovf_main[0];
   assign set_flag[1] = ovf_main[1] | ovf_hi[0] | ovf_hi[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '{default: '0};
         run_q   <= '0;
         flag_q  <= '0;
         pulse_q <= 1'b0;
      end else begin
         if (wr_cfg) begin
            for (int c = 0; c < NUM_CH; c++)
               cfg_q[c] <= chan_cfg_t'(reg_wdata[c*CFG_W +: CFG_W]);
         end
         if (wr_ctl) begin
            run_q  <= reg_wdata[NUM_CH-1:0];
            flag_q <= reg_wdata[2*NUM_CH-1:NUM_CH];
         end else begin
            flag_q <= (flag_q & ~flag_ack) | set_flag;
         end
         pulse_q <= ovf_main[1];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(0): reg_rdata = cnt_lo[0];
         ADDR_W'(1): reg_rdata = cnt_hi[0];
         ADDR_W'(2): reg_rdata = cnt_lo[1];
         ADDR_W'(3): reg_rdata = cnt_hi[1];
         A_CFG:      reg_rdata[NUM_CH*CFG_W-1:0] = {cfg_q[1], cfg_q[0]};
         A_CTL:      reg_rdata[2*NUM_CH-1:0]     = {flag_q, run_q};
         default:    reg_rdata = '0;
      endcase
   end

   assign ovf_flag     = flag_q;
   assign t1_ovf_pulse = pulse_q;

   // R11: acknowledge clears a flag unless an overflow arrives with it
   assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_ack[0] && !set_flag[0] && !wr_ctl) |=> !ovf_flag[0]);

   // R9: channel 1 split mode holds its count
   assert_t1_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[1].mode == MODE_SPLIT && !wr_lo[1] && !wr_hi[1])
         |=> ($stable(cnt_lo[1]) && $stable(cnt_hi[1])));

   // R7: pulse comes with flag 1
   assert_pulse_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (t1_ovf_pulse && !$past(wr_ctl)) |-> ovf_flag[1]);

   // R7: pulse lasts one cycle per overflow
   assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      t1_ovf_pulse |=> !t1_ovf_pulse);
endmodule

// File: tb/test_dual_timer_counter.sv
`timescale 1ns/1ps
module test_dual_timer_counter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_tick = 1'b0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [1:0] cnt_pin = '0, gate_pin = '0, flag_ack = '0;
   logic [1:0] ovf_flag;
   logic       t1_ovf_pulse;
   int checks = 0, errors = 0;
   logic [7:0] v, v2;

   always #10 clk = ~clk;  // 50 MHz

   dual_timer_counter i_dual_timer_counter (
      .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cnt_pin(cnt_pin), .gate_pin(gate_pin), .flag_ack(flag_ack),
      .ovf_flag(ovf_flag), .t1_ovf_pulse(t1_ovf_pulse)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic mtick(input int n);
      for (int k = 0; k < n; k++) begin
         repeat (11) @(negedge clk);
         cyc_tick = 1'b1;
         @(negedge clk);
         cyc_tick = 1'b0;
      end
   endtask

   // expected {flag, hi, lo} after n ticks in a counting mode
   function automatic logic [16:0] expect_cnt(input int mode, input logic [7:0] hi,
                                              input logic [7:0] lo, input int n);
      logic [16:0] s;
      logic [13:0] t;
      logic [7:0]  l;
      logic        f;
      case (mode)
         0: begin
            t = {1'b0, hi, lo[4:0]} + 14'(n);
            return {t[13], t[12:5], lo[7:5], t[4:0]};
         end
         1: begin
            s = {1'b0, hi, lo} + 17'(n);
            return s;
         end
         default: begin
            l = lo; f = 1'b0;
            for (int k = 0; k < n; k++) begin
               if (l == 8'hFF) begin l = hi; f = 1'b1; end
               else l = l + 8'd1;
            end
            return {f, hi, l};
         end
      endcase
   endfunction

   initial begin
      #3_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [16:0] e;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), v);
         check(v == 8'h00, "R1 reset register", v, 0);
      end
      check(ovf_flag == 2'b00 && t1_ovf_pulse == 1'b0, "R1 flags/pulse", {ovf_flag, t1_ovf_pulse}, 0);

      // R2 register map
      wr(0, 8'h12); wr(1, 8'h34); wr(2, 8'h56); wr(3, 8'h78); wr(4, 8'hA5);
      rd(0, v); check(v == 8'h12, "R2 addr0", v, 8'h12);
      rd(1, v); check(v == 8'h34, "R2 addr1", v, 8'h34);
      rd(2, v); check(v == 8'h56, "R2 addr2", v, 8'h56);
      rd(3, v); check(v == 8'h78, "R2 addr3", v, 8'h78);
      rd(4, v); check(v == 8'hA5, "R2 cfg", v, 8'hA5);
      wr(5, 8'hF0);
      rd(5, v); check(v == 8'h00, "R2 ctl upper bits", v, 0);
      rd(6, v); check(v == 8'h00, "R2 unused addr", v, 0);

      // R3 timer function, 16-bit on channel 0
      wr(4, 8'h01); wr(0, 8'h00); wr(1, 8'h00); wr(5, 8'h01);
      mtick(37);
      rd(0, v); rd(1, v2);
      check({v2, v} == 16'd37, "R3 counts ticks", {v2, v}, 37);
      wr(5, 8'h00);
      mtick(5);
      rd(0, v); check(v == 8'd37, "R3 run clear holds", v, 37);

      // R4 gate
      wr(4, 8'h09); wr(0, 8'h00); wr(5, 8'h01);
      gate_pin[0] = 1'b0;
      mtick(10);
      rd(0, v); check(v == 8'h00, "R4 gate low blocks", v, 0);
      gate_pin[0] = 1'b1;
      mtick(10);
      rd(0, v); check(v == 8'd10, "R4 gate high counts", v, 10);
      gate_pin[0] = 1'b0;

      // R5 counter function on channel 1
      wr(4, 8'h50); wr(2, 8'h00); wr(3, 8'h00); wr(5, 8'h02);
      for (int p = 0; p < 6; p++) begin
         cnt_pin[1] = 1'b1; mtick(2);
         cnt_pin[1] = 1'b0; mtick(2);
      end
      rd(2, v); check(v == 8'd6, "R5 falling edges", v, 6);
      for (int p = 0; p < 8; p++) begin
         cnt_pin[1] = ~cnt_pin[1]; mtick(1);
      end
      rd(2, v); check(v == 8'd10, "R5 fastest toggling", v, 10);
      @(negedge clk); cnt_pin[1] = 1'b1;
      repeat (3) @(negedge clk); cnt_pin[1] = 1'b0;
      mtick(2);
      rd(2, v); check(v == 8'd10, "R5 short pulse ignored", v, 10);

      // R6 13-bit mode on channel 0
      wr(5, 8'h00); wr(4, 8'h00); wr(1, 8'hFF); wr(0, 8'hFD); wr(5, 8'h01);
      mtick(2);
      rd(0, v); rd(1, v2);
      check(v == 8'hFF && v2 == 8'hFF && ovf_flag[0] == 1'b0, "R6 before wrap", {v2, v}, 16'hFFFF);
      mtick(1);
      rd(0, v); rd(1, v2);
      check(v == 8'hE0 && v2 == 8'h00, "R6 wrap keeps upper bits", {v2, v}, 16'h00E0);
      check(ovf_flag[0] == 1'b1, "R6 flag", ovf_flag[0], 1);

      // R7 16-bit overflow and pulse on channel 1
      wr(5, 8'h00); wr(4, 8'h10); wr(2, 8'hFE); wr(3, 8'hFF); wr(5, 8'h02);
      mtick(1);
      check(ovf_flag[1] == 1'b0 && t1_ovf_pulse == 1'b0, "R7 no early flag", ovf_flag[1], 0);
      mtick(1);
      rd(2, v); rd(3, v2);
      check({v2, v} == 16'h0000, "R7 rollover", {v2, v}, 0);
      check(ovf_flag[1] == 1'b1 && t1_ovf_pulse == 1'b1, "R7 flag and pulse", {ovf_flag[1], t1_ovf_pulse}, 3);
      @(negedge clk);
      check(t1_ovf_pulse == 1'b0, "R7 pulse one cycle", t1_ovf_pulse, 0);

      // R8 reload mode on channel 0
      wr(5, 8'h00); wr(4, 8'h02); wr(1, 8'hF0); wr(0, 8'hFE); wr(5, 8'h01);
      mtick(1);
      rd(0, v); check(v == 8'hFF && ovf_flag[0] == 1'b0, "R8 reach FF", v, 8'hFF);
      mtick(1);
      rd(0, v); rd(1, v2);
      check(v == 8'hF0 && v2 == 8'hF0, "R8 reload", {v2, v}, 16'hF0F0);
      check(ovf_flag[0] == 1'b1, "R8 flag", ovf_flag[0], 1);
      mtick(16);
      rd(0, v); check(v == 8'hF0, "R8 second reload", v, 8'hF0);

      // R9, R10 split mode
      wr(5, 8'h00); wr(4, 8'h33);
      wr(0, 8'hFE); wr(1, 8'hFE); wr(2, 8'h34); wr(3, 8'h12);
      wr(5, 8'h03);
      mtick(2);
      rd(0, v); rd(1, v2);
      check(v == 8'h00 && v2 == 8'h00, "R10 both bytes wrap", {v2, v}, 0);
      check(ovf_flag == 2'b11 && t1_ovf_pulse == 1'b0, "R10 flags no pulse", {ovf_flag, t1_ovf_pulse}, 6);
      rd(2, v); rd(3, v2);
      check({v2, v} == 16'h1234, "R9 channel 1 holds", {v2, v}, 16'h1234);
      wr(5, 8'h02);
      mtick(3);
      rd(0, v); rd(1, v2);
      check(v == 8'h00 && v2 == 8'h03, "R10 high byte on run 1 only", {v2, v}, 16'h0300);

      // R11 acknowledge
      wr(5, 8'h0C);
      check(ovf_flag == 2'b11, "R12 flags written", ovf_flag, 3);
      @(negedge clk); flag_ack = 2'b01;
      @(negedge clk); flag_ack = 2'b00;
      check(ovf_flag == 2'b10, "R11 ack clears flag 0", ovf_flag, 2);
      wr(5, 8'h00); wr(4, 8'h02); wr(1, 8'h00); wr(0, 8'hFF); wr(5, 8'h01);
      flag_ack = 2'b01;
      mtick(1);
      flag_ack = 2'b00;
      check(ovf_flag[0] == 1'b1, "R11 set beats ack", ovf_flag[0], 1);

      // R12 write beats increment
      wr(5, 8'h00); wr(4, 8'h01); wr(0, 8'h10); wr(1, 8'h00); wr(5, 8'h01);
      repeat (11) @(negedge clk);
      cyc_tick = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h55;
      @(negedge clk);
      cyc_tick = 1'b0; reg_wr = 1'b0;
      rd(0, v); check(v == 8'h55, "R12 write wins", v, 8'h55);

      // random runs in the three counting modes (R6, R7, R8)
      for (int it = 0; it < 9; it++) begin
         int m, n;
         logic [7:0] h0, l0;
         m  = int'($urandom_range(2, 0));
         n  = int'($urandom_range(300, 1));
         h0 = 8'($urandom);
         l0 = 8'($urandom);
         if (it % 3 == 0) begin h0 = 8'hFF; l0 = 8'hF0; end
         wr(5, 8'h00); wr(4, 8'(m)); wr(0, l0); wr(1, h0); wr(5, 8'h01);
         mtick(n);
         e = expect_cnt(m, h0, l0, n);
         rd(0, v); rd(1, v2);
         check({v2, v} == e[15:0], "R6 R7 R8 random count", {v2, v}, e[15:0]);
         check(ovf_flag[0] == e[16], "R6 R7 R8 random flag", ovf_flag[0], e[16]);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule